// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block runs the acknowledge step for a pair of eight-input interrupt units wired as a cascade: a primary unit that talks to the processor and a secondary unit whose output feeds one input of the primary. When the processor strobes an acknowledge, the sequencer takes the winners that each unit's priority resolver already reports. From these it builds the 8-bit vector the processor reads. It also issues one-cycle update strobes that clear request bits, set in-service bits or move the rotation base inside the two units.

If the primary's winner is the cascade input, the acknowledge passes down to the secondary unit, and the vector is taken from the secondary's base and winning line. If a request vanished between the interrupt signal and the acknowledge, the sequencer returns the spurious vector, which is the lowest-priority line of whichever unit came up empty. A separate forwarder turns a pending secondary request into a single-cycle pulse for the primary's cascade input. The primary therefore sees it as an edge both when the request first appears and after every acknowledge, when both units re-evaluate.

Top module: `cascade_ack_seq`

## Requirements
- R1: An acknowledge accepted at a clock edge makes `vec_vld_o` high for exactly the following cycle. `vec_o` carries the vector in that cycle and holds it until the next accepted acknowledge. The vector is laid out as base in bits [7:3] and line in bits [2:0].
- R2: An acknowledge seen while `vec_vld_o` is high is ignored: at the next edge `vec_vld_o` and all update strobes fall to 0 and `vec_o` is unchanged.
- R3: For each acknowledged unit, `*_irr_clr_o` has the bit of the winning line set only if that line's bit in `*_lvl_i` is 0 (edge-triggered). A line whose level bit is 1 keeps its request.
- R4: With `*_aeoi_i` = 0, `*_isr_set_o` is one-hot on the acknowledged line and no rotation strobe is issued.
- R5: With `*_aeoi_i` = 1, `*_isr_set_o` stays 0. If `*_rot_i` is also 1, `*_rot_we_o` pulses and `*_rot_base_o` = (line + 1) mod 8; otherwise `*_rot_we_o` stays 0.
- R6: If the primary winner is line 2 and the secondary reports a winner, both units are updated, and the vector is `slv_base_i`*8 + secondary line.
- R7: If the primary winner is line 2 and the secondary reports none, the primary is updated, the secondary gets no strobes, and the vector is `slv_base_i`*8 + 7.
- R8: If the primary reports no winner, no unit is updated and the vector is `mst_base_i`*8 + 7.
- R9: `cas_o` is high for one cycle after `slv_vld_i` rises, and for one cycle after a `vec_vld_o` cycle while `slv_vld_i` is high. It is never high in two consecutive cycles.
- R10: During and directly after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_i | input | 1 | Acknowledge strobe from the processor side |
| mst_vld_i | input | 1 | Primary resolver has a winner |
| mst_line_i | input | 3 | Primary winning line |
| slv_vld_i | input | 1 | Secondary resolver has a winner |
| slv_line_i | input | 3 | Secondary winning line |
| mst_base_i | input | 5 | Primary vector base (vector bits 7:3) |
| slv_base_i | input | 5 | Secondary vector base (vector bits 7:3) |
| mst_lvl_i | input | 8 | Primary level-trigger mask, 1 = level |
| slv_lvl_i | input | 8 | Secondary level-trigger mask, 1 = level |
| mst_aeoi_i | input | 1 | Primary automatic end of interrupt |
| mst_rot_i | input | 1 | Primary rotate on automatic end of interrupt |
| slv_aeoi_i | input | 1 | Secondary automatic end of interrupt |
| slv_rot_i | input | 1 | Secondary rotate on automatic end of interrupt |
| vec_o | output | 8 | Acknowledge vector |
| vec_vld_o | output | 1 | Vector valid, also the re-evaluate strobe |
| mst_irr_clr_o | output | 8 | Primary request-bit clear strobe |
| mst_isr_set_o | output | 8 | Primary in-service set strobe |
| mst_rot_we_o | output | 1 | Primary rotation base write |
| mst_rot_base_o | output | 3 | Primary new rotation base |
| slv_irr_clr_o | output | 8 | Secondary request-bit clear strobe |
| slv_isr_set_o | output | 8 | Secondary in-service set strobe |
| slv_rot_we_o | output | 1 | Secondary rotation base write |
| slv_rot_base_o | output | 3 | Secondary new rotation base |
| cas_o | output | 1 | Pulse for the primary's cascade input |

## Verification
The hardest case to reach is the combination of a cascade selection on the primary with an empty secondary. It only arises when the secondary's request disappears between the interrupt and the acknowledge. The bench reaches it directly by driving the resolver results as free inputs, and it sweeps every primary line, every secondary line, both valid states of each unit and all four end-of-interrupt flag combinations. Level masks and bases change on every step, so each vector and strobe is checked against values the bench computes itself. The cascade pulse is checked in directed sequences that cover a fresh secondary request and a re-evaluation after an acknowledge.

// File: rtl/ackseq_pkg.sv
package ackseq_pkg;
  parameter int unsigned NUM_LINES = 8;
  localparam int unsigned LINE_W = $clog2(NUM_LINES);

  typedef struct packed {
    logic [NUM_LINES-1:0] irr_clr;
    logic [NUM_LINES-1:0] isr_set;
    logic                 rot_we;
    logic [LINE_W-1:0]    rot_base;
  } unit_upd_t;
endpackage

// File: rtl/ackseq_unit_upd.sv
module ackseq_unit_upd
  import ackseq_pkg::*;
(
  input  logic                 en_i,
  input  logic [LINE_W-1:0]    line_i,
  input  logic [NUM_LINES-1:0] lvl_i,
  input  logic                 aeoi_i,
  input  logic                 rot_i,
  output unit_upd_t            upd_o
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

  always_comb begin
    upd_o = '0;
    if (en_i) begin
      // edge-triggered requests are consumed, level ones stay
      if (!lvl_i[line_i]) upd_o.irr_clr[line_i] = 1'b1;
      if (!aeoi_i) begin
        upd_o.isr_set[line_i] = 1'b1;
      end else if (rot_i) begin
        upd_o.rot_we   = 1'b1;
        upd_o.rot_base = (line_i == LAST_LINE) ? '0 : line_i + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ackseq_cas_fwd.sv
module ackseq_cas_fwd (
  input  logic clk,
  input  logic rst_n,
  input  logic slv_vld_i,
  input  logic reeval_i,
  output logic cas_o
);
  logic vld_q, cas_q, cas_d, trig;

  // new secondary request, or re-evaluation while one is pending
  assign trig  = slv_vld_i & (~vld_q | reeval_i);
  assign cas_d = trig & ~cas_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cas_q <= 1'b0;
    end else begin
      vld_q <= slv_vld_i;
      cas_q <= cas_d;
    end
  end

  assign cas_o = cas_q;

  AST_CAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_q |=> !cas_q); // R9
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
  import ackseq_pkg::*;
#(
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned CAS_LINE = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ack_i,
  input  logic                        mst_vld_i,
  input  logic [LINE_W-1:0]           mst_line_i,
  input  logic                        slv_vld_i,
  input  logic [LINE_W-1:0]           slv_line_i,
  input  logic [VEC_W-LINE_W-1:0]     mst_base_i,
  input  logic [VEC_W-LINE_W-1:0]     slv_base_i,
  input  logic [NUM_LINES-1:0]        mst_lvl_i,
  input  logic [NUM_LINES-1:0]        slv_lvl_i,
  input  logic                        mst_aeoi_i,
  input  logic                        mst_rot_i,
  input  logic                        slv_aeoi_i,
  input  logic                        slv_rot_i,
  output logic [VEC_W-1:0]            vec_o,
  output logic                        vec_vld_o,
  output logic [NUM_LINES-1:0]        mst_irr_clr_o,
  output logic [NUM_LINES-1:0]        mst_isr_set_o,
  output logic                        mst_rot_we_o,
  output logic [LINE_W-1:0]           mst_rot_base_o,
  output logic [NUM_LINES-1:0]        slv_irr_clr_o,
  output logic [NUM_LINES-1:0]        slv_isr_set_o,
  output logic                        slv_rot_we_o,
  output logic [LINE_W-1:0]           slv_rot_base_o,
  output logic                        cas_o
);
  localparam int unsigned BASE_W = VEC_W - LINE_W;
  localparam int unsigned UNITS  = 2;
  localparam logic [LINE_W-1:0] SPUR    = LINE_W'(NUM_LINES - 1);
  localparam logic [LINE_W-1:0] CAS_SEL = LINE_W'(CAS_LINE);

  logic              vld_q;
  logic [VEC_W-1:0]  vec_q, vec_d;
  logic              accept, sel_cas;
  logic [UNITS-1:0]  u_en, u_aeoi, u_rot;
  logic [LINE_W-1:0] u_line [UNITS];
  logic [NUM_LINES-1:0] u_lvl [UNITS];
  unit_upd_t         upd_d [UNITS];
  unit_upd_t         upd_q [UNITS];

  // an acknowledge is taken only when no vector is being presented
  assign accept  = ack_i & ~vld_q;
  assign sel_cas = mst_line_i == CAS_SEL;

  assign u_en[0]   = accept & mst_vld_i;
  assign u_en[1]   = accept & mst_vld_i & sel_cas & slv_vld_i;
  assign u_line[0] = mst_line_i;
  assign u_line[1] = slv_line_i;
  assign u_lvl[0]  = mst_lvl_i;
  assign u_lvl[1]  = slv_lvl_i;
  assign u_aeoi    = {slv_aeoi_i, mst_aeoi_i};
  assign u_rot     = {slv_rot_i, mst_rot_i};

  always_comb begin
    if (!mst_vld_i)       vec_d = {mst_base_i, SPUR};
    else if (!sel_cas)    vec_d = {mst_base_i, mst_line_i};
    else if (slv_vld_i)   vec_d = {slv_base_i, slv_line_i};
    else                  vec_d = {slv_base_i, SPUR};
  end

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    ackseq_unit_upd i_upd (
      .en_i   (u_en[g]),
      .line_i (u_line[g]),
      .lvl_i  (u_lvl[g]),
      .aeoi_i (u_aeoi[g]),
      .rot_i  (u_rot[g]),
      .upd_o  (upd_d[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q[g] <= '0;
      else        upd_q[g] <= upd_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= accept;
      if (accept) vec_q <= vec_d;
    end
  end

  ackseq_cas_fwd i_cas (
    .clk       (clk),
    .rst_n     (rst_n),
    .slv_vld_i (slv_vld_i),
    .reeval_i  (vld_q),
    .cas_o     (cas_o)
  );

  assign vec_o          = vec_q;
  assign vec_vld_o      = vld_q;
  assign mst_irr_clr_o  = upd_q[0].irr_clr;
  assign mst_isr_set_o  = upd_q[0].isr_set;
  assign mst_rot_we_o   = upd_q[0].rot_we;
  assign mst_rot_base_o = upd_q[0].rot_base;
  assign slv_irr_clr_o  = upd_q[1].irr_clr;
  assign slv_isr_set_o  = upd_q[1].isr_set;
  assign slv_rot_we_o   = upd_q[1].rot_we;
  assign slv_rot_base_o = upd_q[1].rot_base;

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_vld_o |-> (mst_irr_clr_o == '0 && mst_isr_set_o == '0 && !mst_rot_we_o
                    && slv_irr_clr_o == '0 && slv_isr_set_o == '0 && !slv_rot_we_o)); // R2
  AST_LEVEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld_o |-> ((mst_irr_clr_o & $past(mst_lvl_i)) == '0)); // R3
  AST_ISR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_isr_set_o) && $onehot0(slv_isr_set_o)); // R4
  AST_AEOI_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_vld_o && $past(mst_aeoi_i)) |-> mst_isr_set_o == '0); // R5
  AST_SPUR_MST: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_vld_o && !$past(mst_vld_i)) |-> (vec_o[LINE_W-1:0] == SPUR)); // R8
endmodule

// File: tb/test_cascade_ack_seq.sv
module test_cascade_ack_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic ack_i, mst_vld_i, slv_vld_i;
  logic [2:0] mst_line_i, slv_line_i;
  logic [4:0] mst_base_i, slv_base_i;
  logic [7:0] mst_lvl_i, slv_lvl_i;
  logic mst_aeoi_i, mst_rot_i, slv_aeoi_i, slv_rot_i;
  logic [7:0] vec_o;
  logic vec_vld_o;
  logic [7:0] mst_irr_clr_o, mst_isr_set_o, slv_irr_clr_o, slv_isr_set_o;
  logic mst_rot_we_o, slv_rot_we_o;
  logic [2:0] mst_rot_base_o, slv_rot_base_o;
  logic cas_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascade_ack_seq i_cascade_ack_seq (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // expected strobes of one unit, computed from the requirements
  task automatic chk_unit(input string who, input bit en, input int line, input logic [7:0] lvl,
                          input bit aeoi, input bit rot, input logic [7:0] irr,
                          input logic [7:0] isr, input bit we, input logic [2:0] rb);
    int e_irr, e_isr, e_we, e_rb;
    e_irr = (en && !lvl[line]) ? (1 << line) : 0;
    e_isr = (en && !aeoi) ? (1 << line) : 0;
    e_we  = (en && aeoi && rot) ? 1 : 0;
    e_rb  = e_we ? ((line + 1) % 8) : 0;
    chk_eq({"R3 ", who, " irr_clr"}, irr, e_irr);
    chk_eq({aeoi ? "R5 " : "R4 ", who, " isr_set"}, isr, e_isr);
    chk_eq({"R5 ", who, " rot_we"}, we, e_we);
    chk_eq({"R5 ", who, " rot_base"}, rb, e_rb);
  endtask

  initial begin
    rst_n = 1'b0; ack_i = 0; mst_vld_i = 0; slv_vld_i = 0;
    mst_line_i = 0; slv_line_i = 0; mst_base_i = 0; slv_base_i = 0;
    mst_lvl_i = 0; slv_lvl_i = 0;
    mst_aeoi_i = 0; mst_rot_i = 0; slv_aeoi_i = 0; slv_rot_i = 0;
    repeat (3) @(negedge clk);
    // R10: outputs idle in reset
    chk_eq("R10 vec_vld", vec_vld_o, 0);
    chk_eq("R10 vec", vec_o, 0);
    chk_eq("R10 strobes", {mst_irr_clr_o, mst_isr_set_o, slv_irr_clr_o, slv_isr_set_o}, 0);
    chk_eq("R10 cas", cas_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R10 after release", {vec_vld_o, cas_o, mst_rot_we_o, slv_rot_we_o}, 0);

    // sweep R1 R3 R4 R5 R6 R7 R8
    for (int it = 0; it < 1024; it++) begin
      int mv, ml, sv, sl, md, ev;
      string vreq;
      mv = it[0]; sv = it[1]; md = it[3:2]; ml = it[6:4]; sl = it[9:7];
      @(negedge clk);
      mst_vld_i = mv[0]; slv_vld_i = sv[0];
      mst_line_i = ml[2:0]; slv_line_i = sl[2:0];
      mst_base_i = it[4:0] ^ 5'h0b; slv_base_i = ~it[4:0];
      mst_lvl_i = 8'ha5 ^ it[7:0]; slv_lvl_i = 8'h3c ^ it[9:2];
      mst_aeoi_i = md[0]; mst_rot_i = md[1]; slv_aeoi_i = md[1]; slv_rot_i = md[0];
      ack_i = 1'b1;
      if (!mv) begin
        ev = mst_base_i * 8 + 7; vreq = "R8 vector";
      end else if (ml != 2) begin
        ev = mst_base_i * 8 + ml; vreq = "R1 vector";
      end else if (sv) begin
        ev = slv_base_i * 8 + sl; vreq = "R6 vector";
      end else begin
        ev = slv_base_i * 8 + 7; vreq = "R7 vector";
      end
      @(negedge clk);
      chk_eq("R1 vec_vld", vec_vld_o, 1);
      chk_eq(vreq, vec_o, ev);
      chk_unit("mst", mv == 1, ml, mst_lvl_i, mst_aeoi_i, mst_rot_i,
               mst_irr_clr_o, mst_isr_set_o, mst_rot_we_o, mst_rot_base_o);
      chk_unit(sv ? "R6 slv" : "R7 slv", (mv == 1) && (ml == 2) && (sv == 1), sl, slv_lvl_i,
               slv_aeoi_i, slv_rot_i, slv_irr_clr_o, slv_isr_set_o, slv_rot_we_o, slv_rot_base_o);
      if (it % 2 == 0) begin
        // R2: acknowledge held into the valid cycle is ignored
        @(negedge clk);
        chk_eq("R2 vec_vld", vec_vld_o, 0);
        chk_eq("R2 vec held", vec_o, ev);
        chk_eq("R2 no strobes", {mst_irr_clr_o, mst_isr_set_o, slv_irr_clr_o, slv_isr_set_o,
                                 6'(0), mst_rot_we_o, slv_rot_we_o}, 0);
        ack_i = 1'b0;
      end else begin
        ack_i = 1'b0;
        @(negedge clk);
        chk_eq("R1 vec_vld drop", vec_vld_o, 0);
        chk_eq("R1 vec held", vec_o, ev);
      end
    end

    // R9: cascade pulse on a fresh secondary request
    @(negedge clk);
    slv_vld_i = 0; mst_vld_i = 0;
    repeat (3) @(negedge clk);
    chk_eq("R9 cas idle", cas_o, 0);
    slv_vld_i = 1'b1;
    @(negedge clk);
    chk_eq("R9 cas rise", cas_o, 1);
    @(negedge clk);
    chk_eq("R9 cas fall", cas_o, 0);
    @(negedge clk);
    chk_eq("R9 cas stays low", cas_o, 0);
    // R9: re-evaluation after an acknowledge
    mst_vld_i = 1; mst_line_i = 3'd2; slv_line_i = 3'd5; ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk_eq("R9 vec_vld", vec_vld_o, 1);
    chk_eq("R9 cas during valid", cas_o, 0);
    @(negedge clk);
    chk_eq("R9 cas reeval", cas_o, 1);
    @(negedge clk);
    chk_eq("R9 cas reeval fall", cas_o, 0);
    // R9: no pulse after re-evaluation without secondary request
    slv_vld_i = 1'b0; ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    @(negedge clk);
    chk_eq("R9 no cas without request", cas_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule